// File: doc/BRIEF.md
# Multi-Pointer Auto-Step Address Unit

This block keeps a bank of four 24-bit address pointers for a byte-oriented processor core. Each pointer is held as three byte registers (low, high and extended), and a small select register picks which pointer is active. The active pointer drives the 24-bit address output. A core uses it for block moves and table walks: it loads pointers through a byte-wide register port, then steps the active pointer with an explicit increment strobe or, when that pointer's auto-step bit is set, with the completion strobe of each data access.

Each pointer has its own direction bit. When the bit is set, every step of that pointer moves it down by one instead of up. Stepping wraps modulo 2^24, with carry and borrow passing through all three bytes. A separate toggle strobe flips only the lowest select bit. Pointers therefore pair up as 0/1 and 2/3, and the toggle never leaves the current pair.

Register writes have priority over stepping. A write to any byte of the active pointer in the same cycle as a step cancels the step. Instruction decode and the memory access itself live outside the block.

Top module: `addr_ptr_bank`

## Requirements
- R1: After a synchronous reset, every pointer byte, the select field, all direction bits, all auto-step bits and ptr_addr are zero.
- R2: Register map on reg_addr:
  - Byte b of pointer n is at address 4n+b, with b=0 the low byte, b=1 the high byte and b=2 the extended byte.
  - Address 16 holds the select field in bits 1:0.
  - Address 17 holds the direction bits, bit n for pointer n.
  - Address 18 holds the auto-step enables, bit n for pointer n.
  - reg_rdata returns, one clock after the address is applied, the value held before that edge.
  - Any other address reads zero and ignores writes.
- R3: ptr_addr equals the active pointer's value and is updated at the same clock edge as the pointer or select state it follows.
- R4: inc_strobe steps the active pointer by one: up when its direction bit is 0, down when it is 1. The other pointers keep their values.
- R5: Steps wrap modulo 2^24, with carry and borrow across all three bytes (FFFFFF+1 gives 000000, 000000-1 gives FFFFFF, 0000FF+1 gives 000100).
- R6: access_done steps the active pointer only when that pointer's auto-step bit is 1. Otherwise it has no effect.
- R7: inc_strobe and access_done in the same cycle produce a single step.
- R8: sel_toggle inverts only bit 0 of the select field (1 becomes 0, 3 becomes 2). A write to address 16 in the same cycle wins over the toggle.
- R9: A write to any byte of the active pointer in the same cycle as a step cancels the step. The written byte takes reg_wdata and the other bytes of that pointer keep their values.
- R10: A step in the same cycle as a select write acts on the pointer selected before the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 5 | Register address for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| inc_strobe | input | 1 | Step the active pointer |
| access_done | input | 1 | Data access completed; steps the active pointer if its auto-step bit is set |
| sel_toggle | input | 1 | Flip the low select bit |
| ptr_addr | output | 24 | Active pointer value |

## Verification
Directed cases load pointers with the values FFFFFF, 000000 and 0000FF and step them in both directions. These show whether carry and borrow ripple through all three bytes rather than wrapping inside one byte. Further directed cases collide a step with a byte write, a step with a select write, and a toggle with a select write; these separate a correct priority from the opposite one. A strobe pair in one cycle separates a single step from a double step. A long constrained-random run mixes writes to every address, toggles and both strobes with random auto-step and direction settings. Each cycle it compares the read data and the active address with a bench model, which exposes stray updates to pointers that are not selected.

// File: rtl/dpb_pkg.sv
package dpb_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/dpb_ptr_slice.sv
module dpb_ptr_slice
  import dpb_pkg::*;
#(
  parameter int PTR_BYTES = 3,
  parameter int OFS_W     = 2,
  localparam int PTR_W    = PTR_BYTES * BYTE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [OFS_W-1:0] wr_ofs,
  input  byte_t            wr_data,
  input  logic             step_en,
  input  logic             step_down,
  output logic [PTR_W-1:0] q,
  output logic [PTR_W-1:0] q_nxt
);

  always_comb begin
    q_nxt = q;
    if (wr_en) begin
      for (int b = 0; b < PTR_BYTES; b++)
        if (wr_ofs == OFS_W'(b)) q_nxt[b*BYTE_W +: BYTE_W] = wr_data;
    end else if (step_en) begin
      q_nxt = step_down ? q - PTR_W'(1) : q + PTR_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= q_nxt;
  end

  // R4 / R5: one step up or down, wrapping across all bytes
  assert_step_up_R4: assert property (@(posedge clk) disable iff (rst)
    step_en && !wr_en && !step_down |=> q == $past(q) + PTR_W'(1));
  assert_step_down_R5: assert property (@(posedge clk) disable iff (rst)
    step_en && !wr_en && step_down |=> q == $past(q) - PTR_W'(1));
  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !step_en && !wr_en |=> $stable(q));

  for (genvar b = 0; b < PTR_BYTES; b++) begin : g_wchk
    assert_write_byte_R9: assert property (@(posedge clk) disable iff (rst)
      wr_en && wr_ofs == OFS_W'(b) |=> q[b*BYTE_W +: BYTE_W] == $past(wr_data));
  end

endmodule

// File: rtl/dpb_ctrl.sv
module dpb_ctrl
  import dpb_pkg::*;
#(
  parameter int NUM_PTR = 4,
  parameter int SEL_W   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sel_wr,
  input  logic               dir_wr,
  input  logic               auto_wr,
  input  byte_t              wdata,
  input  logic               sel_toggle,
  output logic [SEL_W-1:0]   sel_q,
  output logic [SEL_W-1:0]   sel_nxt,
  output logic [NUM_PTR-1:0] dir_q,
  output logic [NUM_PTR-1:0] auto_q
);

  always_comb begin
    sel_nxt = sel_q;
    if (sel_wr)          sel_nxt = wdata[SEL_W-1:0];
    else if (sel_toggle) sel_nxt[0] = ~sel_q[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= '0;
      dir_q  <= '0;
      auto_q <= '0;
    end else begin
      sel_q <= sel_nxt;
      if (dir_wr)  dir_q  <= wdata[NUM_PTR-1:0];
      if (auto_wr) auto_q <= wdata[NUM_PTR-1:0];
    end
  end

  // R8: toggle stays inside the pointer pair
  assert_toggle_pair_R8: assert property (@(posedge clk) disable iff (rst)
    sel_toggle && !sel_wr |=> (sel_q ^ $past(sel_q)) == SEL_W'(1));
  assert_sel_write_R8: assert property (@(posedge clk) disable iff (rst)
    sel_wr |=> sel_q == $past(wdata[SEL_W-1:0]));

endmodule

// File: rtl/addr_ptr_bank.sv
module addr_ptr_bank
  import dpb_pkg::*;
#(
  parameter int NUM_PTR   = 4,
  parameter int PTR_BYTES = 3,
  parameter int ADDR_W    = 5,
  localparam int PTR_W    = PTR_BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  byte_t             reg_wdata,
  output byte_t             reg_rdata,
  input  logic              inc_strobe,
  input  logic              access_done,
  input  logic              sel_toggle,
  output logic [PTR_W-1:0]  ptr_addr
);

  localparam int SEL_W     = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1;
  localparam int OFS_W     = $clog2(PTR_BYTES);
  localparam int IDX_W     = ADDR_W - OFS_W;
  localparam int STRIDE    = 1 << OFS_W;
  localparam int CTRL_BASE = NUM_PTR * STRIDE;
  localparam logic [ADDR_W-1:0] SEL_A  = ADDR_W'(CTRL_BASE);
  localparam logic [ADDR_W-1:0] DIR_A  = ADDR_W'(CTRL_BASE + 1);
  localparam logic [ADDR_W-1:0] AUTO_A = ADDR_W'(CTRL_BASE + 2);

  logic [NUM_PTR-1:0][PTR_W-1:0] ptr_q, ptr_n;
  logic [NUM_PTR-1:0]            wr_hit, step_en, dir_q, auto_q;
  logic [SEL_W-1:0]              sel_q, sel_nxt;
  logic [IDX_W-1:0]              a_idx;
  logic [OFS_W-1:0]              a_ofs;
  logic                          a_in_ptr, step_req;
  byte_t                         rd_d;

  assign a_idx    = reg_addr[ADDR_W-1:OFS_W];
  assign a_ofs    = reg_addr[OFS_W-1:0];
  assign a_in_ptr = (reg_addr < SEL_A) && ({1'b0, a_ofs} < (OFS_W+1)'(PTR_BYTES));
  assign step_req = inc_strobe | (access_done & auto_q[sel_q]);

  dpb_ctrl #(.NUM_PTR(NUM_PTR), .SEL_W(SEL_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .sel_wr     (reg_wr && reg_addr == SEL_A),
    .dir_wr     (reg_wr && reg_addr == DIR_A),
    .auto_wr    (reg_wr && reg_addr == AUTO_A),
    .wdata      (reg_wdata),
    .sel_toggle (sel_toggle),
    .sel_q      (sel_q),
    .sel_nxt    (sel_nxt),
    .dir_q      (dir_q),
    .auto_q     (auto_q)
  );

  for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptr
    assign wr_hit[i]  = reg_wr && a_in_ptr && (a_idx == IDX_W'(i));
    assign step_en[i] = step_req && (sel_q == SEL_W'(i)) && !wr_hit[i];

    dpb_ptr_slice #(.PTR_BYTES(PTR_BYTES), .OFS_W(OFS_W)) u_slice (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (wr_hit[i]),
      .wr_ofs    (a_ofs),
      .wr_data   (reg_wdata),
      .step_en   (step_en[i]),
      .step_down (dir_q[i]),
      .q         (ptr_q[i]),
      .q_nxt     (ptr_n[i])
    );
  end

  always_comb begin
    rd_d = '0;
    if (a_in_ptr) begin
      for (int i = 0; i < NUM_PTR; i++)
        for (int b = 0; b < PTR_BYTES; b++)
          if (a_idx == IDX_W'(i) && a_ofs == OFS_W'(b))
            rd_d = ptr_q[i][b*BYTE_W +: BYTE_W];
    end else if (reg_addr == SEL_A) begin
      rd_d[SEL_W-1:0] = sel_q;
    end else if (reg_addr == DIR_A) begin
      rd_d[NUM_PTR-1:0] = dir_q;
    end else if (reg_addr == AUTO_A) begin
      rd_d[NUM_PTR-1:0] = auto_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_addr  <= '0;
      reg_rdata <= '0;
    end else begin
      ptr_addr  <= ptr_n[sel_nxt];
      reg_rdata <= rd_d;
    end
  end

  // R3: output tracks the selected pointer
  assert_out_tracks_R3: assert property (@(posedge clk) disable iff (rst)
    ptr_addr == ptr_q[sel_q]);
  // R7: at most one pointer steps, and only once
  assert_single_step_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(step_en));
  // R6: completion strobe ignored when auto-step is off
  assert_quiet_done_R6: assert property (@(posedge clk) disable iff (rst)
    access_done && !inc_strobe && !auto_q[sel_q] && !reg_wr && !sel_toggle
    |=> $stable(ptr_addr));
  // R9: write to the active pointer cancels its step
  assert_write_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_hit & step_en) == '0);

endmodule

// File: tb/addr_ptr_bank_test.sv
module addr_ptr_bank_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        inc_strobe = 1'b0, access_done = 1'b0, sel_toggle = 1'b0;
  logic [23:0] ptr_addr;

  int n_checks = 0, n_fail = 0;
  logic [23:0] m_ptr [4];
  logic [1:0]  m_sel;
  logic [3:0]  m_dir, m_auto;

  always #2 clk = ~clk;

  addr_ptr_bank uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .inc_strobe(inc_strobe),
    .access_done(access_done), .sel_toggle(sel_toggle), .ptr_addr(ptr_addr)
  );

  task automatic chk(input string tag, input logic [23:0] got, input logic [23:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] m_read(input logic [4:0] a);
    if (a < 5'd16 && a[1:0] != 2'd3) return m_ptr[a[3:2]][a[1:0]*8 +: 8];
    if (a == 5'd16) return {6'd0, m_sel};
    if (a == 5'd17) return {4'd0, m_dir};
    if (a == 5'd18) return {4'd0, m_auto};
    return 8'd0;
  endfunction

  task automatic cyc(input logic wr, input logic [4:0] a, input logic [7:0] wd,
                     input logic inc, input logic acc, input logic tog,
                     input string ptag, input string rtag);
    logic [7:0] exp_rd;
    logic       hit, step, ptr_a;
    reg_wr = wr; reg_addr = a; reg_wdata = wd;
    inc_strobe = inc; access_done = acc; sel_toggle = tog;
    exp_rd = m_read(a);
    ptr_a = (a < 5'd16) && (a[1:0] != 2'd3);
    hit   = wr && ptr_a && (a[3:2] == m_sel);
    step  = (inc || (acc && m_auto[m_sel])) && !hit;
    if (step) m_ptr[m_sel] = m_dir[m_sel] ? m_ptr[m_sel] - 24'd1 : m_ptr[m_sel] + 24'd1;
    if (wr) begin
      if (ptr_a)            m_ptr[a[3:2]][a[1:0]*8 +: 8] = wd;
      else if (a == 5'd16)  m_sel  = wd[1:0];
      else if (a == 5'd17)  m_dir  = wd[3:0];
      else if (a == 5'd18)  m_auto = wd[3:0];
    end
    if (tog && !(wr && a == 5'd16)) m_sel[0] = ~m_sel[0];
    @(posedge clk); #1;
    chk(rtag, {16'd0, reg_rdata}, {16'd0, exp_rd});
    chk(ptag, ptr_addr, m_ptr[m_sel]);
  endtask

  task automatic wr_ptr(input int n, input logic [23:0] v, input string tag);
    for (int b = 0; b < 3; b++)
      cyc(1'b1, 5'(n*4 + b), v[b*8 +: 8], 1'b0, 1'b0, 1'b0, tag, "R2");
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) m_ptr[i] = '0;
    m_sel = '0; m_dir = '0; m_auto = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    chk("R1", ptr_addr, 24'd0);
    for (int a = 0; a < 20; a++) cyc(1'b0, 5'(a), 8'h00, 1'b0, 1'b0, 1'b0, "R1", "R1");

    // R2 map, then R5 wrap upward on pointer 0
    wr_ptr(0, 24'hFFFFFF, "R2");
    cyc(1'b0, 5'd2, 8'h00, 1'b1, 1'b0, 1'b0, "R5", "R2");
    chk("R5", ptr_addr, 24'h000000);
    // R4 decrement with direction bit, borrow across bytes
    cyc(1'b1, 5'd17, 8'h01, 1'b0, 1'b0, 1'b0, "R4", "R2");
    cyc(1'b0, 5'd0, 8'h00, 1'b1, 1'b0, 1'b0, "R4", "R2");
    chk("R5", ptr_addr, 24'hFFFFFF);
    // carry low->high on pointer 1
    cyc(1'b1, 5'd16, 8'h01, 1'b0, 1'b0, 1'b0, "R3", "R2");
    wr_ptr(1, 24'h0000FF, "R2");
    cyc(1'b0, 5'd5, 8'h00, 1'b1, 1'b0, 1'b0, "R5", "R2");
    chk("R5", ptr_addr, 24'h000100);
    // R8 toggle 1->0 and 3->2
    cyc(1'b0, 5'd16, 8'h00, 1'b0, 1'b0, 1'b1, "R8", "R8");
    cyc(1'b0, 5'd16, 8'h00, 1'b0, 1'b0, 1'b0, "R8", "R8");
    chk("R8", {22'd0, m_sel}, 24'd0);
    cyc(1'b1, 5'd16, 8'h03, 1'b0, 1'b0, 1'b0, "R8", "R8");
    cyc(1'b0, 5'd16, 8'h00, 1'b0, 1'b0, 1'b1, "R8", "R8");
    cyc(1'b0, 5'd16, 8'h00, 1'b0, 1'b0, 1'b0, "R8", "R8");
    chk("R8", {22'd0, m_sel}, 24'd2);
    // R8 select write beats toggle
    cyc(1'b1, 5'd16, 8'h02, 1'b0, 1'b0, 1'b1, "R8", "R8");
    cyc(1'b0, 5'd16, 8'h00, 1'b0, 1'b0, 1'b0, "R8", "R8");
    // R6 access_done ignored without auto bit, honoured with it
    wr_ptr(2, 24'h123456, "R2");
    cyc(1'b0, 5'd8, 8'h00, 1'b0, 1'b1, 1'b0, "R6", "R6");
    chk("R6", ptr_addr, 24'h123456);
    cyc(1'b1, 5'd18, 8'h04, 1'b0, 1'b0, 1'b0, "R6", "R2");
    cyc(1'b0, 5'd18, 8'h00, 1'b0, 1'b1, 1'b0, "R6", "R6");
    chk("R6", ptr_addr, 24'h123457);
    // R7 both strobes: one step
    cyc(1'b0, 5'd8, 8'h00, 1'b1, 1'b1, 1'b0, "R7", "R7");
    chk("R7", ptr_addr, 24'h123458);
    // R9 write to active pointer cancels step
    cyc(1'b1, 5'd9, 8'hAB, 1'b1, 1'b0, 1'b0, "R9", "R9");
    chk("R9", ptr_addr, 24'h12AB58);
    // R10 select write with step acts on old pointer
    cyc(1'b1, 5'd16, 8'h03, 1'b1, 1'b0, 1'b0, "R10", "R10");
    cyc(1'b1, 5'd16, 8'h02, 1'b0, 1'b0, 1'b0, "R10", "R10");
    chk("R10", ptr_addr, 24'h12AB59);

    // R4 random mix
    void'($urandom(32'd20240611));
    for (int k = 0; k < 3000; k++) begin
      logic [4:0] a;
      a = 5'($urandom % 20);
      cyc(($urandom % 10) < 3, a, 8'($urandom), ($urandom % 10) < 4,
          ($urandom % 10) < 4, ($urandom % 10) < 1, "R4 random", "R2 random");
    end
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule